// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

This block turns one fast clock into the full set of logic-level drive waveforms for a four-phase interline CCD sensor in an interlaced 625-line monochrome camera. Each pixel period is four clock ticks. A pixel counter, a line counter and a field toggle run from that clock. Every drive signal is decoded from these counters and then registered once, so all outputs share the same latency. The drive signals are the two horizontal register clocks, the reset gate, the four vertical transfer phases, two readout strobes (one for the V1 lane, one for the V3 lane) and the substrate shutter pulse. The block also produces horizontal and vertical blanking and sync, a field flag, a clamp window and a marker for the vertical dummy line.

A line is made of a blanking interval followed by the horizontal dummy bits, the leading optical-black pixels, the effective pixels and the trailing optical-black pixels. With the default parameters there are 795 sensor pixels per row: 3 + 752 + 40. Vertical transfer, readout and the shutter pulse all fall inside the blanking interval. The exposure length is set by a line-count input that is read once per field.

Top module: `ccdtg_top`

## Requirements
- R1: A pixel period is 4 clock ticks. A line is HBLANK_PIX+HDUMMY+HOB_FRONT+HEFF+HOB_REAR pixels long. `hBlank` is high for the first HBLANK_PIX pixels of each line and `hSync` for the first HSYNC_PIX pixels.
- R2: `hClk1` and `hClk2` are never low together. Outside the vertical shift window, `hClk1` is high in ticks 0–1 of a pixel and `hClk2` in ticks 2–3. `resetGate` pulses high for tick 1 of every such pixel.
- R3: For the 4*VSTEP pixels starting at pixel VSH_START of each line, `hClk1` stays high and `hClk2` and `resetGate` stay low. The vertical phases change only inside this window.
- R4: `vPhase` (bit 0 = V1 … bit 3 = V4) rests at 4'b0011. Once per line it steps through 0110, 1100, 1001 and back to 0011, one step every VSTEP pixels, always with two adjacent phases high.
- R5: Readout happens on the first line of each field. Each readout strobe lasts RD_PIX pixels. In the odd field (`fieldEven`=0), `readV1` starts at pixel RD_A and `readV3` at pixel RD_B. In the even field the two lanes swap.
- R6: The odd field lasts ceil(FRAME_LINES/2) lines with `fieldEven`=0, and the even field lasts floor(FRAME_LINES/2) lines with `fieldEven`=1.
- R7: `subPulse` is high for SUB_PIX pixels from pixel SUB_START on every field line whose index is below (field length − shutter setting). A setting of at least the field length gives no pulses.
- R8: `shutterLines` is sampled only at the first tick of a field. Changing it later in the field has no effect until the next field.
- R9: `clampWin` covers exactly the trailing optical-black pixels, the last HOB_REAR pixels of the line.
- R10: `vBlank` is high for the first VBLANK_LINES lines of each field and `vSync` for the first VSYNC_LINES. `vDummy` marks field line VBLANK_LINES in even fields only.
- R11: While reset is held: `hClk1`=1, `hClk2`=0, `resetGate`=0, `vPhase`=4'b0011, and the readout strobes, `subPulse` and `fieldEven` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, four ticks per pixel |
| rst | input | 1 | Synchronous reset, active high |
| shutterLines | input | SH_W | Exposure length in lines before readout |
| hClk1 | output | 1 | Horizontal register clock, phase 1 |
| hClk2 | output | 1 | Horizontal register clock, phase 2 |
| resetGate | output | 1 | Output-node reset gate pulse |
| vPhase | output | 4 | Vertical transfer phases V1..V4 (bit 0 = V1) |
| readV1 | output | 1 | Readout strobe on the V1 lane |
| readV3 | output | 1 | Readout strobe on the V3 lane |
| subPulse | output | 1 | Substrate discharge (shutter) pulse |
| hBlank | output | 1 | Horizontal blanking |
| hSync | output | 1 | Horizontal sync |
| vBlank | output | 1 | Vertical blanking |
| vSync | output | 1 | Vertical sync |
| fieldEven | output | 1 | 0 in the odd field, 1 in the even field |
| clampWin | output | 1 | Optical-black clamp window |
| vDummy | output | 1 | Even-field vertical dummy line |

## Verification
The bench checks the readout position in both fields. A design that failed to swap the lanes, or that read on the wrong line, would put `readV3` ahead of `readV1` in the odd field or move the strobe away from 16 pixels after the field start. The substrate pulse count is checked for shutter settings of zero, mid-range and beyond the field length. An off-by-one in the window compare would give one pulse too many or too few, and a missing clamp at the limit would wrap and give a full set of pulses. The bench also changes the setting in mid-field; a design that did not latch it would react within the same field. Throughout the run, the bench watches for both horizontal clocks low together and for any horizontal edge during a vertical step.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

  // One tick worth of decoded timing, handed from control to datapath.
  typedef struct packed {
    logic [1:0] pixQ;
    logic       shiftOn;
    logic       vStep;
    logic       subOn;
    logic       rdV1On;
    logic       rdV3On;
    logic       hBlank;
    logic       hSync;
    logic       vBlank;
    logic       vSync;
    logic       fieldEven;
    logic       clamp;
    logic       vDummy;
  } drvStrobe_t;

  function automatic logic [3:0] phaseOf(input logic [1:0] idx);
    case (idx)
      2'd0:    phaseOf = 4'b0011;
      2'd1:    phaseOf = 4'b0110;
      2'd2:    phaseOf = 4'b1100;
      default: phaseOf = 4'b1001;
    endcase
  endfunction

endpackage

// File: rtl/ccdtg_ctrl.sv
module ccdtg_ctrl
  import ccdtg_pkg::*;
#(
  parameter int HBLANK_PIX   = 200,
  parameter int HDUMMY       = 22,
  parameter int HOB_FRONT    = 3,
  parameter int HEFF         = 752,
  parameter int HOB_REAR     = 40,
  parameter int HSYNC_PIX    = 64,
  parameter int VSH_START    = 20,
  parameter int VSTEP        = 16,
  parameter int SUB_START    = 88,
  parameter int SUB_PIX      = 24,
  parameter int RD_A         = 116,
  parameter int RD_B         = 156,
  parameter int RD_PIX       = 36,
  parameter int FRAME_LINES  = 625,
  parameter int VBLANK_LINES = 22,
  parameter int VSYNC_LINES  = 3,
  parameter int SH_W         = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SH_W-1:0] shutterLines,
  output drvStrobe_t      st
);
  localparam int LINE_PIX    = HBLANK_PIX + HDUMMY + HOB_FRONT + HEFF + HOB_REAR;
  localparam int CLAMP_START = LINE_PIX - HOB_REAR;
  localparam int ODD_LINES   = (FRAME_LINES + 1) / 2;
  localparam int EVEN_LINES  = FRAME_LINES / 2;
  localparam int HC_W        = $clog2(LINE_PIX);
  localparam int LN_W        = $clog2(ODD_LINES + 1);
  localparam int VSH_END     = VSH_START + 4 * VSTEP;

  logic [1:0]      pixQ;
  logic [HC_W-1:0] hCnt;
  logic [LN_W-1:0] fLine;
  logic            fieldEven;
  logic [SH_W-1:0] shLat;
  logic [31:0]     hNum, lNum, shNum, lenNum;
  logic            fieldStart, stepHit;

  assign hNum   = 32'(hCnt);
  assign lNum   = 32'(fLine);
  assign shNum  = 32'(shLat);
  assign lenNum = fieldEven ? 32'(EVEN_LINES) : 32'(ODD_LINES);
  assign fieldStart = (pixQ == 2'd0) && (hNum == 0) && (lNum == 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixQ      <= '0;
      hCnt      <= '0;
      fLine     <= '0;
      fieldEven <= 1'b0;
      shLat     <= '0;
    end else begin
      pixQ <= pixQ + 2'd1;
      if (pixQ == 2'd3) begin
        if (hNum == LINE_PIX - 1) begin
          hCnt <= '0;
          if (lNum == lenNum - 1) begin
            fLine     <= '0;
            fieldEven <= ~fieldEven;
          end else begin
            fLine <= fLine + 1'b1;
          end
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end
      if (fieldStart) shLat <= shutterLines;
    end
  end

  // Vertical steps land mid-pixel so they never share a tick with an H edge.
  always_comb begin
    stepHit = 1'b0;
    for (int k = 0; k < 4; k++)
      if (hNum == 32'(VSH_START + k * VSTEP)) stepHit = 1'b1;
  end

  logic rdAOn, rdBOn, firstLine;
  assign firstLine = (lNum == 0);
  assign rdAOn = firstLine && (hNum >= RD_A) && (hNum < RD_A + RD_PIX);
  assign rdBOn = firstLine && (hNum >= RD_B) && (hNum < RD_B + RD_PIX);

  always_comb begin
    st.pixQ      = pixQ;
    st.shiftOn   = (hNum >= VSH_START) && (hNum < VSH_END);
    st.vStep     = stepHit && (pixQ == 2'd2);
    st.subOn     = (lNum + shNum < lenNum) && (hNum >= SUB_START) &&
                   (hNum < SUB_START + SUB_PIX);
    st.rdV1On    = fieldEven ? rdBOn : rdAOn;
    st.rdV3On    = fieldEven ? rdAOn : rdBOn;
    st.hBlank    = hNum < HBLANK_PIX;
    st.hSync     = hNum < HSYNC_PIX;
    st.vBlank    = lNum < VBLANK_LINES;
    st.vSync     = lNum < VSYNC_LINES;
    st.fieldEven = fieldEven;
    st.clamp     = hNum >= CLAMP_START;
    st.vDummy    = fieldEven && (lNum == VBLANK_LINES);
  end

  // R8: the latched setting moves only at a field boundary
  a_r8_shutter_hold: assert property (@(posedge clk) disable iff (rst)
    !fieldStart |=> $stable(shLat));
  // R5: readout strobes stay inside blanking and never overlap
  a_r5_read_in_blank: assert property (@(posedge clk) disable iff (rst)
    (st.rdV1On || st.rdV3On) |-> (st.hBlank && !(st.rdV1On && st.rdV3On)));
  // R1: pixel counter stays within the line
  a_r1_hcnt_range: assert property (@(posedge clk) disable iff (rst)
    hNum < LINE_PIX);
  // R6: field length never exceeded
  a_r6_line_range: assert property (@(posedge clk) disable iff (rst)
    lNum < lenNum);

endmodule

// File: rtl/ccdtg_drive.sv
module ccdtg_drive
  import ccdtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  drvStrobe_t st,
  output logic       hClk1,
  output logic       hClk2,
  output logic       resetGate,
  output logic [3:0] vPhase,
  output logic       readV1,
  output logic       readV3,
  output logic       subPulse,
  output logic       hBlank,
  output logic       hSync,
  output logic       vBlank,
  output logic       vSync,
  output logic       fieldEven,
  output logic       clampWin,
  output logic       vDummy
);
  logic [1:0] vPh;

  always_ff @(posedge clk) begin
    if (rst) begin
      hClk1     <= 1'b1;
      hClk2     <= 1'b0;
      resetGate <= 1'b0;
      vPh       <= '0;
      readV1    <= 1'b0;
      readV3    <= 1'b0;
      subPulse  <= 1'b0;
      hBlank    <= 1'b0;
      hSync     <= 1'b0;
      vBlank    <= 1'b0;
      vSync     <= 1'b0;
      fieldEven <= 1'b0;
      clampWin  <= 1'b0;
      vDummy    <= 1'b0;
    end else begin
      hClk1     <= st.shiftOn | ~st.pixQ[1];
      hClk2     <= ~st.shiftOn & st.pixQ[1];
      resetGate <= ~st.shiftOn & (st.pixQ == 2'd1);
      if (st.vStep) vPh <= vPh + 2'd1;
      readV1    <= st.rdV1On;
      readV3    <= st.rdV3On;
      subPulse  <= st.subOn;
      hBlank    <= st.hBlank;
      hSync     <= st.hSync;
      vBlank    <= st.vBlank;
      vSync     <= st.vSync;
      fieldEven <= st.fieldEven;
      clampWin  <= st.clamp;
      vDummy    <= st.vDummy;
    end
  end

  assign vPhase = phaseOf(vPh);

  // R2: horizontal clocks always keep one phase high
  a_r2_not_both_low: assert property (@(posedge clk) disable iff (rst)
    hClk1 || hClk2);
  // R2: reset gate only fires while phase 1 is high
  a_r2_rg_in_h1: assert property (@(posedge clk) disable iff (rst)
    resetGate |-> (hClk1 && !hClk2));
  // R3: a vertical step finds the horizontal clocks parked and unchanged
  a_r3_h_frozen: assert property (@(posedge clk) disable iff (rst)
    (vPhase != $past(vPhase)) |-> (hClk1 && !hClk2 && $past(hClk1) && !$past(hClk2)));
  // R4: exactly two vertical phases high
  a_r4_two_high: assert property (@(posedge clk) disable iff (rst)
    $countones(vPhase) == 2);

endmodule

// File: rtl/ccdtg_top.sv
module ccdtg_top
  import ccdtg_pkg::*;
#(
  parameter int HBLANK_PIX   = 200,
  parameter int HDUMMY       = 22,
  parameter int HOB_FRONT    = 3,
  parameter int HEFF         = 752,
  parameter int HOB_REAR     = 40,
  parameter int HSYNC_PIX    = 64,
  parameter int VSH_START    = 20,
  parameter int VSTEP        = 16,
  parameter int SUB_START    = 88,
  parameter int SUB_PIX      = 24,
  parameter int RD_A         = 116,
  parameter int RD_B         = 156,
  parameter int RD_PIX       = 36,
  parameter int FRAME_LINES  = 625,
  parameter int VBLANK_LINES = 22,
  parameter int VSYNC_LINES  = 3,
  parameter int SH_W         = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SH_W-1:0] shutterLines,
  output logic            hClk1,
  output logic            hClk2,
  output logic            resetGate,
  output logic [3:0]      vPhase,
  output logic            readV1,
  output logic            readV3,
  output logic            subPulse,
  output logic            hBlank,
  output logic            hSync,
  output logic            vBlank,
  output logic            vSync,
  output logic            fieldEven,
  output logic            clampWin,
  output logic            vDummy
);
  drvStrobe_t strobes;

  ccdtg_ctrl #(
    .HBLANK_PIX(HBLANK_PIX), .HDUMMY(HDUMMY), .HOB_FRONT(HOB_FRONT),
    .HEFF(HEFF), .HOB_REAR(HOB_REAR), .HSYNC_PIX(HSYNC_PIX),
    .VSH_START(VSH_START), .VSTEP(VSTEP), .SUB_START(SUB_START),
    .SUB_PIX(SUB_PIX), .RD_A(RD_A), .RD_B(RD_B), .RD_PIX(RD_PIX),
    .FRAME_LINES(FRAME_LINES), .VBLANK_LINES(VBLANK_LINES),
    .VSYNC_LINES(VSYNC_LINES), .SH_W(SH_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .shutterLines(shutterLines), .st(strobes)
  );

  ccdtg_drive u_drive (
    .clk(clk), .rst(rst), .st(strobes),
    .hClk1(hClk1), .hClk2(hClk2), .resetGate(resetGate), .vPhase(vPhase),
    .readV1(readV1), .readV3(readV3), .subPulse(subPulse),
    .hBlank(hBlank), .hSync(hSync), .vBlank(vBlank), .vSync(vSync),
    .fieldEven(fieldEven), .clampWin(clampWin), .vDummy(vDummy)
  );

endmodule

// File: tb/ccdtg_top_bench.sv
`timescale 1ns/1ps
module ccdtg_top_bench;
  localparam int HBL = 24, HDM = 2, HOF = 1, HEF = 8, HOR = 3;
  localparam int LINE = HBL + HDM + HOF + HEF + HOR;   // 38 pixels
  localparam int LCLK = LINE * 4;                      // 152 ticks
  localparam int HSY = 4, VSS = 2, VST = 2, SBS = 12, SBP = 3;
  localparam int RDA = 16, RDB = 20, RDP = 2;
  localparam int FRM = 11, VBL = 2, VSY = 1;
  localparam int ODDL = 6, EVENL = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] shutter = 4'd0;
  logic hClk1, hClk2, resetGate, readV1, readV3, subPulse;
  logic hBlank, hSync, vBlank, vSync, fieldEven, clampWin, vDummy;
  logic [3:0] vPhase;

  int total = 0, bad = 0;
  int lowBoth = 0, frozenBad = 0, sameLvl = 0;
  bit started = 0;

  always #4 clk = ~clk;

  ccdtg_top #(
    .HBLANK_PIX(HBL), .HDUMMY(HDM), .HOB_FRONT(HOF), .HEFF(HEF), .HOB_REAR(HOR),
    .HSYNC_PIX(HSY), .VSH_START(VSS), .VSTEP(VST), .SUB_START(SBS), .SUB_PIX(SBP),
    .RD_A(RDA), .RD_B(RDB), .RD_PIX(RDP), .FRAME_LINES(FRM),
    .VBLANK_LINES(VBL), .VSYNC_LINES(VSY), .SH_W(4)
  ) u_ccdtg_top (
    .clk(clk), .rst(rst), .shutterLines(shutter),
    .hClk1(hClk1), .hClk2(hClk2), .resetGate(resetGate), .vPhase(vPhase),
    .readV1(readV1), .readV3(readV3), .subPulse(subPulse),
    .hBlank(hBlank), .hSync(hSync), .vBlank(vBlank), .vSync(vSync),
    .fieldEven(fieldEven), .clampWin(clampWin), .vDummy(vDummy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // continuous watch on the horizontal clocks (R2, R3)
  logic [3:0] vPrev = 4'b0011;
  logic h1Prev = 1'b1, h2Prev = 1'b0;
  always @(negedge clk) begin
    if (started && !rst) begin
      if (!hClk1 && !hClk2) lowBoth++;
      if (hClk1 == hClk2) sameLvl++;
      if (vPhase != vPrev && !(hClk1 && !hClk2 && h1Prev && !h2Prev)) frozenBad++;
    end
    vPrev = vPhase; h1Prev = hClk1; h2Prev = hClk2;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run did not end", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic waitHsyncRise();
    logic p;
    do begin p = hSync; @(negedge clk); end while (!(hSync && !p));
  endtask

  task automatic waitOddStart();
    logic p;
    do begin p = fieldEven; @(negedge clk); end while (!(p && !fieldEven));
  endtask

  int sLen, sSub, sSubHigh, sRd1, sRd3, sRd1T, sRd3T, sRd1High, sDum, sVb, sVs;

  // scans from the first sample of a field up to the first sample of the next
  task automatic scanField(input int changeAt, input logic [3:0] newSh);
    logic f0, pS, p1, p3;
    f0 = fieldEven; pS = subPulse; p1 = readV1; p3 = readV3;
    sLen = 0; sSub = 0; sSubHigh = 0; sRd1 = 0; sRd3 = 0; sRd1T = -1; sRd3T = -1;
    sRd1High = 0; sDum = 0; sVb = 0; sVs = 0;
    while (fieldEven == f0) begin
      if (sLen == changeAt) shutter = newSh;
      if (subPulse && !pS) sSub++;
      if (subPulse) sSubHigh++;
      if (readV1 && !p1) begin sRd1++; if (sRd1T < 0) sRd1T = sLen; end
      if (readV3 && !p3) begin sRd3++; if (sRd3T < 0) sRd3T = sLen; end
      if (readV1) sRd1High++;
      if (vDummy) sDum++;
      if (vBlank) sVb++;
      if (vSync) sVs++;
      pS = subPulse; p1 = readV1; p3 = readV3;
      sLen++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(hClk1 == 1'b1, "R11", "hClk1 in reset", int'(hClk1), 1);
    chk(hClk2 == 1'b0, "R11", "hClk2 in reset", int'(hClk2), 0);
    chk(resetGate == 1'b0, "R11", "resetGate in reset", int'(resetGate), 0);
    chk(vPhase == 4'b0011, "R11", "vPhase in reset", int'(vPhase), 3);
    chk(!readV1 && !readV3 && !subPulse, "R11", "read/sub in reset",
        int'({readV1, readV3, subPulse}), 0);
    chk(fieldEven == 1'b0, "R11", "fieldEven in reset", int'(fieldEven), 0);
  endtask

  task automatic t_line();
    int hs = 0, hb = 0, cl = 0, clRise = -1, rg = 0;
    logic pc, pr;
    waitHsyncRise();
    pc = clampWin; pr = resetGate;
    for (int t = 0; t < LCLK; t++) begin
      if (hSync) hs++;
      if (hBlank) hb++;
      if (clampWin) cl++;
      if (clampWin && !pc && clRise < 0) clRise = t;
      if (resetGate && !pr) rg++;
      pc = clampWin; pr = resetGate;
      @(negedge clk);
    end
    chk(hs == HSY * 4, "R1", "hSync ticks per line", hs, HSY * 4);
    chk(hb == HBL * 4, "R1", "hBlank ticks per line", hb, HBL * 4);
    chk(cl == HOR * 4, "R9", "clamp ticks per line", cl, HOR * 4);
    chk(clRise == (LINE - HOR) * 4, "R9", "clamp start tick", clRise, (LINE - HOR) * 4);
    chk(rg == LINE - 4 * VST, "R2", "reset gate pulses per line", rg, LINE - 4 * VST);
  endtask

  task automatic t_vshift();
    int changes = 0, badPat = 0, firstT = -1;
    logic [3:0] p;
    waitHsyncRise();
    p = vPhase;
    for (int t = 0; t < LCLK; t++) begin
      if (!(vPhase inside {4'b0011, 4'b0110, 4'b1100, 4'b1001})) badPat++;
      if (vPhase != p) begin changes++; if (firstT < 0) firstT = t; end
      p = vPhase;
      @(negedge clk);
    end
    chk(changes == 4, "R4", "vertical steps per line", changes, 4);
    chk(badPat == 0, "R4", "non-adjacent phase patterns", badPat, 0);
    chk(firstT == VSS * 4 + 2, "R4", "first step tick", firstT, VSS * 4 + 2);
    chk(vPhase == 4'b0011, "R4", "rest pattern after line", int'(vPhase), 3);
  endtask

  task automatic t_fields();
    shutter = 4'd0;
    waitOddStart();
    scanField(-1, 4'd0);
    chk(sLen == ODDL * LCLK, "R6", "odd field ticks", sLen, ODDL * LCLK);
    chk(sRd1 == 1 && sRd3 == 1, "R5", "odd readout pulse count", sRd1 + sRd3, 2);
    chk(sRd1T == RDA * 4, "R5", "odd readV1 position", sRd1T, RDA * 4);
    chk(sRd3T == RDB * 4, "R5", "odd readV3 position", sRd3T, RDB * 4);
    chk(sRd1High == RDP * 4, "R5", "readV1 width", sRd1High, RDP * 4);
    chk(sDum == 0, "R10", "odd field dummy ticks", sDum, 0);
    chk(sVb == VBL * LCLK, "R10", "odd vBlank ticks", sVb, VBL * LCLK);
    chk(sVs == VSY * LCLK, "R10", "odd vSync ticks", sVs, VSY * LCLK);
    chk(sSub == ODDL, "R7", "odd pulses, setting 0", sSub, ODDL);
    chk(sSubHigh == ODDL * SBP * 4, "R7", "sub pulse width total", sSubHigh, ODDL * SBP * 4);
    scanField(-1, 4'd0);
    chk(sLen == EVENL * LCLK, "R6", "even field ticks", sLen, EVENL * LCLK);
    chk(sRd3T == RDA * 4, "R5", "even readV3 position", sRd3T, RDA * 4);
    chk(sRd1T == RDB * 4, "R5", "even readV1 position", sRd1T, RDB * 4);
    chk(sDum == LCLK, "R10", "even field dummy ticks", sDum, LCLK);
    chk(sVb == VBL * LCLK, "R10", "even vBlank ticks", sVb, VBL * LCLK);
    chk(sSub == EVENL, "R7", "even pulses, setting 0", sSub, EVENL);
  endtask

  task automatic t_shutter(input logic [3:0] sh, input int expOdd, input int expEven);
    shutter = sh;
    waitOddStart();
    scanField(-1, sh);
    scanField(-1, sh);
    chk(sSub == expEven, "R7", $sformatf("even pulses, setting %0d", sh), sSub, expEven);
    scanField(-1, sh);
    chk(sSub == expOdd, "R7", $sformatf("odd pulses, setting %0d", sh), sSub, expOdd);
  endtask

  task automatic t_midchange();
    shutter = 4'd1;
    waitOddStart();
    scanField(-1, 4'd1);
    scanField(200, 4'd6);
    chk(sSub == EVENL - 1, "R8", "mid-field change ignored", sSub, EVENL - 1);
    scanField(-1, 4'd6);
    chk(sSub == 0, "R8", "new setting from next field", sSub, 0);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    started = 1'b1;
    t_line();
    t_vshift();
    t_fields();
    t_shutter(4'd2, ODDL - 2, EVENL - 2);
    t_shutter(4'd5, 1, 0);
    t_shutter(4'd9, 0, 0);
    t_midchange();
    chk(lowBoth == 0, "R2", "ticks with both H clocks low", lowBoth, 0);
    chk(sameLvl == 0, "R2", "ticks with H clocks equal", sameLvl, 0);
    chk(frozenBad == 0, "R3", "vertical steps with H clocks moving", frozenBad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule